// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers up to 32 interrupt lines into one request to a processor. Each line passes through a synchronizer. A build-time mask then chooses how the line is captured. A line set to edge capture latches a request on a rising edge. A line set to level capture latches a request on every cycle the line is high.

Software works through a 32-bit word-addressed register bus. Through this bus it reads the latched requests, the enabled requests and the enable mask. It changes enables in three ways: a plain load, an atomic set, or an atomic clear. It acknowledges requests by writing ones. It reads a vector register that holds the lowest-numbered request that is both latched and enabled. A two-bit master control must have both bits set before the request output to the processor can rise.

Reads are combinational from the current register state. Writes take effect at the clock edge on which the bus strobe and write flag are both high.

Top module: `vec_intc`

## Requirements
- R1: After reset, the status, enable and master registers read zero, the vector register reads 0xFFFFFFFF, and `irq_out` is low.
- R2: On a line whose kind-mask bit is 1 (edge capture), a rising edge sets its status bit. The bit stays set after the line falls, until software acknowledges it.
- R3: On a line whose kind-mask bit is 0 (level capture), status is set on every cycle the synchronized line is high. An acknowledge that arrives while the line is still high leaves the bit set. Once the line has fallen, the bit stays latched until an acknowledge clears it.
- R4: Enable register controls. A write to word 2 (0x08) loads the enable register. A write to word 4 (0x10) ORs the written ones into it. A write to word 5 (0x14) clears the written ones. In each case the other bits are kept.
- R5: The pending register (word 1, 0x04) reads status AND enable. With enable at zero, status still latches, while pending stays zero and `irq_out` stays low.
- R6: Writing to word 3 (0x0C) clears exactly the status bits written as 1. Writing 0xFFFFFFFF clears every latched request.
- R7: The vector register (word 6, 0x18) returns the lowest index whose pending bit is set. When no bit is pending it returns 0xFFFFFFFF.
- R8: The master register (word 7, 0x1C) stores bits 1:0 and reads them back with the upper bits zero. `irq_out` is high only when both bits are 1 and at least one pending bit is set.
- R9: Writes to the status (word 0), pending and vector addresses change nothing. Reads of the acknowledge, set-enable and clear-enable addresses return zero.
- R10: A change on an input line reaches its status bit on the third rising clock edge after the line changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Interrupt lines, asynchronous to clk |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_out | output | 1 | Request to the processor |

## Verification
The assertions take for granted that a bus write is a single-cycle strobe, and that a set-enable or clear-enable write is seen in the very next cycle's enable state. They also take for granted that any synchronized line held high on a level input must show up in status one edge later. The stimulus changes `irq_in` and the bus signals only on falling edges, so every capture happens at a known rising edge. Edge pulses are held for at least two cycles, so the synchronizer never misses them.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int          DW        = 32,
  parameter int          SYNC_LEN  = 2,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] irq_in,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [4:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out
);

  localparam logic [2:0] W_STAT = 3'd0, W_PEND = 3'd1, W_EN  = 3'd2, W_ACK = 3'd3,
                         W_SET  = 3'd4, W_CLR  = 3'd5, W_VEC = 3'd6, W_MER = 3'd7;
  localparam logic [DW-1:0] EDGE_SEL = EDGE_MASK[DW-1:0];

  logic [DW-1:0] sync_chain [SYNC_LEN];
  logic [DW-1:0] sync_q, prev_q, status_q, enable_q, pending, vec_val, set_mask;
  logic [1:0]    mer_q;
  logic [2:0]    word;
  logic          wr;

  assign word = bus_addr[4:2];
  assign wr   = bus_en & bus_we;
  wire unused_addr_lsb = &{1'b0, bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_chain[0] <= '0;
    else        sync_chain[0] <= irq_in;

  for (genvar s = 1; s < SYNC_LEN; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_chain[s] <= '0;
      else        sync_chain[s] <= sync_chain[s-1];
  end

  assign sync_q   = sync_chain[SYNC_LEN-1];
  assign set_mask = (EDGE_SEL & sync_q & ~prev_q) | (~EDGE_SEL & sync_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_q;
      status_q <= (status_q & ~((wr && word == W_ACK) ? bus_wdata : '0)) | set_mask;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      enable_q <= '0;
      mer_q    <= '0;
    end else if (wr) begin
      case (word)
        W_EN:    enable_q <= bus_wdata;
        W_SET:   enable_q <= enable_q | bus_wdata;
        W_CLR:   enable_q <= enable_q & ~bus_wdata;
        W_MER:   mer_q    <= bus_wdata[1:0];
        default: ;
      endcase
    end

  assign pending = status_q & enable_q;

  always_comb begin
    vec_val = '1;
    for (int i = DW - 1; i >= 0; i--)
      if (pending[i]) vec_val = DW'(i);
  end

  always_comb begin
    case (word)
      W_STAT:  bus_rdata = status_q;
      W_PEND:  bus_rdata = pending;
      W_EN:    bus_rdata = enable_q;
      W_VEC:   bus_rdata = vec_val;
      W_MER:   bus_rdata = {{(DW-2){1'b0}}, mer_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_out = (&mer_q) & (|pending);

endmodule

// File: rtl/vec_intc_checker.sv
module vec_intc_checker #(
  parameter int          DW        = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [4:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq_out,
  input logic [DW-1:0] sync_q,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] enable_q,
  input logic [1:0]    mer_q,
  input logic [DW-1:0] pending,
  input logic [DW-1:0] vec_val
);
  localparam int IW = $clog2(DW);
  localparam logic [DW-1:0] EM = EDGE_MASK[DW-1:0];

  logic set_wr, clr_wr, ack_wr;
  assign set_wr = bus_en && bus_we && bus_addr[4:2] == 3'd4;
  assign clr_wr = bus_en && bus_we && bus_addr[4:2] == 3'd5;
  assign ack_wr = bus_en && bus_we && bus_addr[4:2] == 3'd3;

  a_r4_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((enable_q & $past(bus_wdata)) == $past(bus_wdata)));

  a_r4_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((enable_q & $past(bus_wdata)) == '0));

  a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> ((($past(status_q) & EM) & ~status_q) == '0));

  a_r3_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_q & ~EM) != '0) |=> ((($past(sync_q) & ~EM) & ~status_q) == '0));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mer_q == 2'b11 && enable_q != '0));

  a_r7_vector_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vec_val == '1));

  a_r7_vector_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_val != '1) |-> (pending[vec_val[IW-1:0]] &&
      ((pending & ((DW'(1) << vec_val[IW-1:0]) - DW'(1))) == '0)));
endmodule

bind vec_intc vec_intc_checker #(.DW(DW), .EDGE_MASK(EDGE_MASK)) u_vec_intc_checker (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .sync_q(sync_q), .status_q(status_q),
  .enable_q(enable_q), .mer_q(mer_q), .pending(pending), .vec_val(vec_val)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN  = 5'h08, A_ACK = 5'h0C,
                         A_SET  = 5'h10, A_CLR  = 5'h14, A_VEC = 5'h18, A_MER = 5'h1C;
  localparam int NT = 22;
  localparam logic [37:0] TBL [NT] = '{
    {1'b0, A_EN,  32'h0000_0000}, {1'b1, A_EN,  32'hA5A5_A5A5},
    {1'b0, A_EN,  32'hA5A5_A5A5}, {1'b1, A_SET, 32'h0000_000F},
    {1'b0, A_EN,  32'hA5A5_A5AF}, {1'b1, A_CLR, 32'hA000_0005},
    {1'b0, A_EN,  32'h05A5_A5AA}, {1'b0, A_SET, 32'h0000_0000},
    {1'b0, A_CLR, 32'h0000_0000}, {1'b0, A_ACK, 32'h0000_0000},
    {1'b1, A_MER, 32'hFFFF_FFFF}, {1'b0, A_MER, 32'h0000_0003},
    {1'b1, A_MER, 32'h0000_0001}, {1'b0, A_MER, 32'h0000_0001},
    {1'b1, A_STAT,32'hFFFF_FFFF}, {1'b0, A_STAT,32'h0000_0000},
    {1'b1, A_PEND,32'hFFFF_FFFF}, {1'b0, A_PEND,32'h0000_0000},
    {1'b1, A_VEC, 32'h0000_0000}, {1'b0, A_VEC, 32'hFFFF_FFFF},
    {1'b1, A_EN,  32'h0000_0000}, {1'b0, A_EN,  32'h0000_0000}
  };

  logic        clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0, bus_wdata = '0, bus_rdata;
  logic        bus_en = 0, bus_we = 0, irq_out;
  logic [4:0]  bus_addr = '0;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  vec_intc i_vec_intc (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 rd = bus_rdata;
    bus_en = 0;
    check(req, rd, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] m);
    irq_in = irq_in | m; cyc(2); irq_in = irq_in & ~m; cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    rdchk("R1", A_STAT, 0); rdchk("R1", A_EN, 0); rdchk("R1", A_MER, 0);
    rdchk("R1", A_VEC, 32'hFFFF_FFFF); check("R1", {31'b0, irq_out}, 0);

    for (int k = 0; k < NT; k++) begin
      if (TBL[k][37]) wr(TBL[k][36:32], TBL[k][31:0]);
      else rdchk(TBL[k][36:32] == A_EN ? "R4" : TBL[k][36:32] == A_MER ? "R8" : "R9",
                 TBL[k][36:32], TBL[k][31:0]);
    end

    // R10 latency: set at negedge, visible after third rising edge
    wr(A_EN, 32'hFFFF_FFFF); wr(A_MER, 3);
    irq_in = 32'h8;
    cyc(2); rdchk("R10", A_STAT, 0);
    cyc(1); rdchk("R10", A_STAT, 32'h8);
    check("R8", {31'b0, irq_out}, 1);
    rdchk("R7", A_VEC, 3);
    // R2 edge hold after line falls
    irq_in = 0; cyc(5); rdchk("R2", A_STAT, 32'h8);
    wr(A_ACK, 32'h8); rdchk("R2", A_STAT, 0);
    check("R8", {31'b0, irq_out}, 0);
    rdchk("R7", A_VEC, 32'hFFFF_FFFF);

    // R3 level capture
    irq_in = 32'h0010_0000; cyc(4);
    rdchk("R3", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000); rdchk("R3", A_STAT, 32'h0010_0000);
    irq_in = 0; cyc(4); rdchk("R3", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000); rdchk("R3", A_STAT, 0);

    // R6 selective acknowledge
    pulse(32'h0000_0204); rdchk("R6", A_STAT, 32'h204);
    wr(A_ACK, 32'h4); rdchk("R6", A_STAT, 32'h200);
    rdchk("R7", A_VEC, 9);
    wr(A_ACK, 32'hFFFF_FFFF); rdchk("R6", A_STAT, 0);

    // R7 priority and masking
    pulse(32'h0000_0022); irq_in = 32'h0010_0000; cyc(4);
    rdchk("R7", A_VEC, 1);
    wr(A_CLR, 32'h2); rdchk("R7", A_VEC, 5);
    rdchk("R5", A_PEND, 32'h0010_0020);
    irq_in = 0; cyc(4);
    wr(A_ACK, 32'hFFFF_FFFF); rdchk("R6", A_STAT, 0);

    // R5 enable zero still latches
    wr(A_EN, 0); pulse(32'h80);
    rdchk("R5", A_STAT, 32'h80); rdchk("R5", A_PEND, 0);
    check("R5", {31'b0, irq_out}, 0);
    rdchk("R7", A_VEC, 32'hFFFF_FFFF);

    // R8 both master bits required
    wr(A_SET, 32'h80); wr(A_MER, 1); check("R8", {31'b0, irq_out}, 0);
    wr(A_MER, 2); check("R8", {31'b0, irq_out}, 0);
    wr(A_MER, 3); check("R8", {31'b0, irq_out}, 1);
    // R9 writes to status ignored with live request
    wr(A_STAT, 0); rdchk("R9", A_STAT, 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule